// File: doc/BRIEF.md
# Two-Port Multicast Destination Filter Table

This block decides, for each received frame, whether its destination MAC address may pass into one of two Ethernet ports that share it. It keeps a table of 32 stored 48-bit addresses. Each stored address is switched on by a bit in a table-enable word and is granted to port 0, port 1 or both by a small per-entry grant field. Each port has its own mode word. Promiscuous mode admits everything. With table filtering off, every multicast destination is admitted. With table filtering on, a multicast destination is admitted only when it matches an enabled entry that grants the requesting port. A destination whose first byte has bit 0 clear is not multicast, and it is always admitted here; unicast address checking happens elsewhere.

Software programs the block through word-addressed 32-bit registers, and reads are combinational. Each address word written into the table starts a short busy window, and a write to a table word issued inside that window is dropped. The receive side presents a lookup request with the destination address and the port number, and gets a registered accept/reject decision one cycle later.

Register map (word addresses): entry i high word at 2i, entry i low word at 2i+1. Table enable is at 0x40. Busy status is at 0x41, in bit 0 (read only). Grant words 0 to 3 are at 0x44 to 0x47. The mode word for port 0 is at 0x48 and the mode word for port 1 is at 0x49. A mode word uses bit 0 for filter-on and bit 1 for promiscuous. All other addresses read as zero.

Top module: `mcast_cam_filter`

## Requirements
- R1: Entry i is held in two words. The word at 2i carries address byte 0 in bits 31:24, byte 1 in 23:16, byte 2 in 15:8 and byte 3 in 7:0. The word at 2i+1 carries byte 4 in bits 15:8 and byte 5 in bits 7:0, and its bits 31:16 are not stored and read as zero.
- R2: A table word write that is taken sets the busy bit (bit 0 at 0x41). The bit reads 1 for exactly 4 cycles after the write edge and then reads 0. Writes to other registers do not set it.
- R3: A table word write issued while busy reads 1 is dropped, and the entry keeps its old contents.
- R4: Entry i takes part in matching only while bit (31 − i) of the table-enable word at 0x40 is 1. Entry 0 maps to bit 31.
- R5: The grant field of entry i is 4 bits wide. It sits in grant word i/8 (at 0x44 + i/8), at bit offset 28 − 4·(i mod 8). Inside the field, bit 3 grants port 0 and bit 1 grants port 1. Bits 2 and 0 are stored but grant nothing.
- R6: A lookup request (lk_req high at an edge) produces lk_valid high with the decision on lk_accept after that edge. lk_valid is low after any edge without a request.
- R7: When the promiscuous bit (bit 1) of the requesting port's mode word is set, every destination is accepted.
- R8: When the promiscuous bit is clear and the filter-on bit (bit 0) of the requesting port's mode word is clear, every multicast destination is accepted.
- R9: With filter-on set and promiscuous clear, a multicast destination is accepted only if some entry is enabled, holds an equal address and grants the requesting port.
- R10: A destination whose address bit 40 (bit 0 of byte 0) is 0 is always accepted.
- R11: Reset clears every entry, the enable word, the grant words, both mode words, the busy bit and lk_valid.
- R12: An entry granted only to the other port does not produce a hit for the requesting port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lk_req | input | 1 | Lookup request |
| lk_dst | input | 48 | Destination address, byte 0 in bits 47:40 |
| lk_port | input | 1 | Requesting port number |
| lk_valid | output | 1 | Decision valid, one cycle after lk_req |
| lk_accept | output | 1 | 1 accepts the frame, 0 rejects it |

## Verification
The assertions watch, on every cycle, the busy window length after each taken table write and the one-cycle timing of lk_valid. They also check that promiscuous mode, filter-off mode and non-multicast destinations always give an accept, and that a filtered multicast with no table hit gives a reject. The bench's scenarios are needed for the rest: the exact placement of address bytes, the reversed enable bit order, the packed grant field positions, the dropping of writes made during busy, the isolation between the two ports and the reset contents. All of these can only be seen through programmed tables and readback.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int CAM_DEPTH   = 32;
  localparam int MAC_W       = 48;
  localparam int WORD_W      = 32;
  localparam int IDX_W       = $clog2(CAM_DEPTH);
  localparam int FIELD_W     = 4;
  localparam int PER_GRANT   = WORD_W / FIELD_W;
  localparam int GRANT_WORDS = CAM_DEPTH / PER_GRANT;
  localparam int RADDR_W     = 7;
  localparam int MODE_FILT   = 0;
  localparam int MODE_PROM   = 1;

  // bit of a grant word that lets `port` use the entry in `slot`
  function automatic int grant_pos(input int slot, input logic port);
    return (WORD_W - FIELD_W) - FIELD_W * slot + 3 - 2 * int'(port);
  endfunction

  // enable bit for entry i (entry 0 is the MSB)
  function automatic int enable_pos(input int idx);
    return CAM_DEPTH - 1 - idx;
  endfunction

  function automatic logic is_group(input logic [MAC_W-1:0] a);
    return a[MAC_W-8];
  endfunction
endpackage

// File: rtl/mcf_busy_timer.sv
module mcf_busy_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= CNT_W'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/mcf_cam_array.sv
module mcf_cam_array
  import mcf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_hi,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic                 rd_hi,
  output logic [WORD_W-1:0]    rd_word,
  input  logic [MAC_W-1:0]     key,
  output logic [CAM_DEPTH-1:0] eq
);
  logic [MAC_W-1:0] ent [CAM_DEPTH];

  for (genvar i = 0; i < CAM_DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) ent[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i)) begin
        if (wr_hi) ent[i][MAC_W-1:16] <= wr_data;
        else       ent[i][15:0]       <= wr_data[15:0];
      end
    end
    assign eq[i] = (ent[i] == key);
  end

  always_comb begin
    if (rd_hi) rd_word = ent[rd_idx][MAC_W-1:16];
    else       rd_word = {16'h0, ent[rd_idx][15:0]};
  end
endmodule

// File: rtl/mcast_cam_filter.sv
module mcast_cam_filter
  import mcf_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic               lk_req,
  input  logic [MAC_W-1:0]   lk_dst,
  input  logic               lk_port,
  output logic               lk_valid,
  output logic               lk_accept
);
  localparam logic [RADDR_W-1:0] A_ENABLE = 7'h40;
  localparam logic [RADDR_W-1:0] A_BUSY   = 7'h41;

  logic [WORD_W-1:0] en_reg;
  logic [WORD_W-1:0] grant_reg [GRANT_WORDS];
  logic [1:0]        mode_reg  [2];

  // decoded access events (named for the checker)
  logic sel_entry, sel_grant, sel_mode;
  logic ent_wr_accept;
  logic busy;
  assign sel_entry     = (reg_addr[RADDR_W-1] == 1'b0);
  assign sel_grant     = (reg_addr[RADDR_W-1:2] == 5'b10001);
  assign sel_mode      = (reg_addr[RADDR_W-1:1] == 6'b100100);
  assign ent_wr_accept = reg_wr && sel_entry && !busy;

  mcf_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(ent_wr_accept), .busy(busy)
  );

  logic [WORD_W-1:0]    ent_word;
  logic [CAM_DEPTH-1:0] addr_eq;
  mcf_cam_array u_cam (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ent_wr_accept), .wr_idx(reg_addr[IDX_W:1]), .wr_hi(!reg_addr[0]),
    .wr_data(reg_wdata),
    .rd_idx(reg_addr[IDX_W:1]), .rd_hi(!reg_addr[0]), .rd_word(ent_word),
    .key(lk_dst), .eq(addr_eq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_reg <= '0;
    end else if (reg_wr && reg_addr == A_ENABLE) begin
      en_reg <= reg_wdata;
    end
  end

  for (genvar g = 0; g < GRANT_WORDS; g++) begin : g_grant
    always_ff @(posedge clk) begin
      if (!rst_n) grant_reg[g] <= '0;
      else if (reg_wr && sel_grant && reg_addr[1:0] == 2'(g)) grant_reg[g] <= reg_wdata;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n) mode_reg[p] <= '0;
      else if (reg_wr && sel_mode && reg_addr[0] == 1'(p)) mode_reg[p] <= reg_wdata[1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_entry)                  reg_rdata = ent_word;
    else if (reg_addr == A_ENABLE)  reg_rdata = en_reg;
    else if (reg_addr == A_BUSY)    reg_rdata = {{(WORD_W-1){1'b0}}, busy};
    else if (sel_grant)             reg_rdata = grant_reg[reg_addr[1:0]];
    else if (sel_mode)              reg_rdata = {{(WORD_W-2){1'b0}}, mode_reg[reg_addr[0]]};
  end

  // per-entry hit: address equal, entry enabled, port granted
  logic [CAM_DEPTH-1:0] hit_vec;
  for (genvar i = 0; i < CAM_DEPTH; i++) begin : g_hit
    assign hit_vec[i] = addr_eq[i] && en_reg[enable_pos(i)] &&
                        grant_reg[i / PER_GRANT][grant_pos(i % PER_GRANT, lk_port)];
  end

  logic hit_any, promisc_sel, filt_sel, dst_group, accept_d;
  assign hit_any     = |hit_vec;
  assign promisc_sel = mode_reg[lk_port][MODE_PROM];
  assign filt_sel    = mode_reg[lk_port][MODE_FILT];
  assign dst_group   = is_group(lk_dst);
  assign accept_d    = promisc_sel || !dst_group || !filt_sel || hit_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid  <= 1'b0;
      lk_accept <= 1'b0;
    end else begin
      lk_valid  <= lk_req;
      lk_accept <= lk_req && accept_d;
    end
  end
endmodule

// File: rtl/mcf_checks.sv
module mcf_checks #(
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_req,
  input logic [47:0] lk_dst,
  input logic        lk_valid,
  input logic        lk_accept,
  input logic        ent_wr_accept,
  input logic        busy,
  input logic        promisc_sel,
  input logic        filt_sel,
  input logic        hit_any
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] win;
  always_ff @(posedge clk) begin
    if (!rst_n)             win <= '0;
    else if (ent_wr_accept) win <= CW'(BUSY_CYCLES);
    else if (win != '0)     win <= win - 1'b1;
  end

  p_busy_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (win != '0));

  p_valid_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_valid);

  p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_valid);

  p_promisc_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && promisc_sel) |=> lk_accept);

  p_filter_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_dst[40] && !filt_sel) |=> lk_accept);

  p_filter_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_dst[40] && filt_sel && !promisc_sel && !hit_any) |=> !lk_accept);

  p_unicast_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_dst[40]) |=> lk_accept);
endmodule

bind mcast_cam_filter mcf_checks #(.BUSY_CYCLES(BUSY_CYCLES)) u_mcf_checks (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_dst(lk_dst),
  .lk_valid(lk_valid), .lk_accept(lk_accept), .ent_wr_accept(ent_wr_accept),
  .busy(busy), .promisc_sel(promisc_sel), .filt_sel(filt_sel), .hit_any(hit_any)
);

// File: tb/test_mcast_cam_filter.sv
module test_mcast_cam_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_req = 1'b0;
  logic [47:0] lk_dst = '0;
  logic        lk_port = 1'b0;
  logic        lk_valid, lk_accept;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mcast_cam_filter i_mcast_cam_filter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
    .lk_dst(lk_dst), .lk_port(lk_port), .lk_valid(lk_valid), .lk_accept(lk_accept)
  );

  // {port, destination, expected accept}
  localparam int NV = 8;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 48'h01005e000001, 1'b1},  // R9 hit, port 0 granted
    {1'b1, 48'h01005e000001, 1'b0},  // R12 granted to port 0 only
    {1'b0, 48'h01005e7ffffa, 1'b1},  // R5 field 0xA grants port 0
    {1'b1, 48'h01005e7ffffa, 1'b1},  // R5 field 0xA grants port 1
    {1'b0, 48'h0180c200000e, 1'b0},  // R5 bits 2,0 grant nothing
    {1'b0, 48'h333300000001, 1'b0},  // R4 entry 31 disabled
    {1'b0, 48'h01005e000002, 1'b0},  // R9 miss
    {1'b1, 48'h001122334455, 1'b1}   // R10 non-multicast
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] b;
    rd(7'h41, b);
    while (b[0]) begin
      @(negedge clk);
      rd(7'h41, b);
    end
  endtask

  task automatic wr_entry(input int idx, input logic [47:0] mac);
    wr(7'(2 * idx), mac[47:16]);
    wait_idle();
    wr(7'(2 * idx + 1), {16'h0, mac[15:0]});
    wait_idle();
  endtask

  task automatic lookup(input logic port, input logic [47:0] dst, output logic v, output logic acc);
    @(negedge clk);
    lk_req = 1'b1; lk_port = port; lk_dst = dst;
    @(negedge clk);
    lk_req = 1'b0;
    v = lk_valid; acc = lk_accept;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic v, a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(7'h40, d); check("R11 enable", 48'(d), 48'h0);
    rd(7'h41, d); check("R11 busy", 48'(d), 48'h0);
    rd(7'h00, d); check("R11 entry", 48'(d), 48'h0);
    rd(7'h48, d); check("R11 mode", 48'(d), 48'h0);
    check("R11 lk_valid", 48'(lk_valid), 48'h0);

    // R6 / R8 with mode cleared: multicast accepted
    lookup(1'b0, 48'h01005e000009, v, a);
    check("R6 valid", 48'(v), 48'h1);
    check("R8 reset mode accept", 48'(a), 48'h1);
    @(negedge clk);
    check("R6 valid drops", 48'(lk_valid), 48'h0);

    // R2 busy window
    wr(7'h00, 32'h01005e00);
    rd(7'h41, d); check("R2 busy cycle1", 48'(d), 48'h1);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk); rd(7'h41, d); check("R2 busy held", 48'(d), 48'h1);
    end
    @(negedge clk); rd(7'h41, d); check("R2 busy clear", 48'(d), 48'h0);
    wr(7'h48, 32'h0);
    rd(7'h41, d); check("R2 non-entry write no busy", 48'(d), 48'h0);

    // R1 layout, upper bits of low word dropped
    wr(7'h01, 32'hffff0001);
    wait_idle();
    rd(7'h00, d); check("R1 high word", 48'(d), 48'h01005e00);
    rd(7'h01, d); check("R1 low word", 48'(d), 48'h0001);

    // program the table
    wr_entry(9, 48'h01005e7ffffa);
    wr_entry(5, 48'h0180c200000e);
    wr_entry(31, 48'h333300000001);
    wr(7'h44, 32'h80000500);
    wr(7'h45, 32'h0a000000);
    wr(7'h47, 32'h00000008);
    wr(7'h40, 32'h84400000);
    wr(7'h48, 32'h1);
    wr(7'h49, 32'h1);

    for (int n = 0; n < NV; n++) begin
      lookup(VEC[n][49], VEC[n][48:1], v, a);
      check($sformatf("R9 vector %0d", n), 48'(a), 48'(VEC[n][0]));
    end

    // R4 enabling entry 31 via bit 0
    wr(7'h40, 32'h84400001);
    lookup(1'b0, 48'h333300000001, v, a);
    check("R4 entry 31 enabled", 48'(a), 48'h1);

    // R8 port 1 filter off
    wr(7'h49, 32'h0);
    lookup(1'b1, 48'h01005e000002, v, a);
    check("R8 filter off", 48'(a), 48'h1);
    lookup(1'b0, 48'h01005e000002, v, a);
    check("R8 port 0 still filtered", 48'(a), 48'h0);

    // R7 promiscuous on port 0
    wr(7'h48, 32'h3);
    lookup(1'b0, 48'h01005e000002, v, a);
    check("R7 promiscuous", 48'(a), 48'h1);

    // R3 write during busy dropped
    wr(7'h04, 32'h01020304);
    wr(7'h04, 32'hdeadbeef);
    wait_idle();
    rd(7'h04, d); check("R3 busy write dropped", 48'(d), 48'h01020304);

    // R11 reset clears programmed state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(7'h12, d); check("R11 entry 9 cleared", 48'(d), 48'h0);
    rd(7'h45, d); check("R11 grant cleared", 48'(d), 48'h0);
    rd(7'h40, d); check("R11 enable cleared", 48'(d), 48'h0);

    finish_run();
  end
endmodule